// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block produces the bit clock for a synchronous serial port, together with two single-cycle strobes that tell the shifting logic when to drive the next bit and when to capture the incoming bit. In internal mode it divides the core clock through three cascaded stages. The first stage selects a divide of 8 or 1 by a range bit. The second is an 8-bit modulus counter that divides by its field value plus one. The last is a toggle that halves the result and gives a 50% duty clock. The bit clock period is therefore 2 x P x (M + 1) core cycles, where P is 8 or 1 and M is the modulus field. In external mode the divider is detached from the pin. An incoming bit clock is brought through a two-flop synchronizer, and its edges produce the same two strobes.

A polarity input selects which bit-clock edge drives data and which samples it. Divider settings are captured into a shadow copy only at the end of a full bit-clock period, so a period in progress always completes with the length it started with. The combination "range bypass with modulus 0" would give a divide by 2 overall. It is rejected: the clock stays low, no strobes are produced and an error flag is set until a legal setting is applied.

Top module: `bclk_gen`

## Requirements
- R1: With `cfg_drive_int`=1, the period of `bclk_o` is 2·P·(M+1) core cycles. P is 8 when `cfg_fast_range`=0 and 1 when it is 1, and M is `cfg_modulus` (0..255). The slowest setting is therefore 4096 cycles and the fastest legal setting is 4 cycles.
- R2: `bclk_o` is high for exactly half of every period.
- R3: With `cfg_pol`=0, `launch_en` pulses in the first core cycle in which `bclk_o` is high and `sample_en` pulses in the first cycle in which it is low. With `cfg_pol`=1 the roles are swapped: launch follows the falling edge and sample follows the rising edge. The same mapping applies to the edges of `ext_bclk` in external mode.
- R4: `launch_en` and `sample_en` are each one core cycle wide and never high together. Each occurs exactly once per bit-clock period.
- R5: With `cfg_drive_int`=1, `cfg_fast_range`=1 and `cfg_modulus`=0, the following holds once the setting is taken: `bclk_o` stays 0, neither strobe fires, and `cfg_err` is 1. While the generator is idle, a legal setting is taken on the next clock edge. `cfg_err` is then 0 one cycle later and the first strobe comes H=P·(M+1) edges after that load.
- R6: Divider settings take effect only at the end of a full period, which is the falling edge of `bclk_o`. A high phase already in progress keeps its old length, and the following low phase uses the new length.
- R7: With `cfg_drive_int`=0, `bclk_o` is held at 0 and `cfg_err` stays 0 whatever the divider fields are. A level change on `ext_bclk` set up before core edge n gives a one-cycle strobe visible after edge n+1, which reflects the two synchronizer stages.
- R8: During reset, `bclk_o`, `launch_en`, `sample_en` and `cfg_err` are 0. The settings are loaded on the first edge after reset, so the first rising edge of `bclk_o` comes H edges after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fast_range | input | 1 | 1 bypasses the divide-by-8 stage |
| cfg_modulus | input | 8 | Modulus field; the divider divides by value + 1 |
| cfg_pol | input | 1 | 0: launch on rising edge, sample on falling edge; 1: swapped |
| cfg_drive_int | input | 1 | 1: internal divider drives the pin; 0: external clock used |
| ext_bclk | input | 1 | External bit clock, asynchronous to `clk` |
| bclk_o | output | 1 | Bit clock toward the pin (0 in external mode) |
| launch_en | output | 1 | One-cycle strobe: drive next data bit |
| sample_en | output | 1 | One-cycle strobe: capture data bit |
| cfg_err | output | 1 | Prohibited divider setting in internal mode |

## Verification
The assertions check the following on every cycle:
- Strobes are exclusive and one cycle wide.
- In internal mode, each edge of `bclk_o` coincides with the strobe that the polarity assigns to it.
- The error state keeps the pin and strobes idle.
- External mode never raises the error flag.

Some behaviour needs the bench's scenarios:
- Absolute period and duty across a sweep of range and modulus values.
- The deferred reload that preserves a half-period in progress.
- The latency of the external synchronizer.
- The first-edge timing after reset and after recovery from the prohibited setting.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    localparam int MOD_W       = 8;
    localparam int PRE_DIV     = 8;
    localparam int SYNC_STAGES = 2;

    // Divider setting captured into the shadow copy.
    typedef struct packed {
        logic             fast;
        logic [MOD_W-1:0] modulus;
    } div_set_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Overall divide by 2 is not allowed.
    function automatic logic set_forbidden(input div_set_t s);
        return s.fast && (s.modulus == '0);
    endfunction

endpackage

// File: rtl/bclk_prescale.sv
module bclk_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bypass,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = bypass || (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bclk_modulus.sv
module bclk_modulus #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         term
);
    logic [W-1:0] cnt_q;

    assign term = tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || term) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bclk_ext_sync.sv
module bclk_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], pin};
        end
    end

    assign rise = pipe_q[STAGES-1] && !pipe_q[STAGES];
    assign fall = !pipe_q[STAGES-1] && pipe_q[STAGES];
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
    import bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fast_range,
    input  logic [MOD_W-1:0] cfg_modulus,
    input  logic             cfg_pol,
    input  logic             cfg_drive_int,
    input  logic             ext_bclk,
    output logic             bclk_o,
    output logic             launch_en,
    output logic             sample_en,
    output logic             cfg_err
);
    div_set_t live_set;
    div_set_t shadow_q;
    phase_e   phase_q;
    logic     run_q;
    logic     err_q;
    logic     rise_q;
    logic     fall_q;

    logic pre_tick;
    logic mod_term;
    logic half_end;
    logic period_end;
    logic load;
    logic ext_rise;
    logic ext_fall;

    assign live_set = '{fast: cfg_fast_range, modulus: cfg_modulus};

    bclk_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (!run_q),
        .bypass (shadow_q.fast),
        .tick   (pre_tick)
    );

    bclk_modulus #(.W(MOD_W)) u_mod (
        .clk   (clk),
        .rst   (rst),
        .clr   (!run_q),
        .tick  (pre_tick),
        .limit (shadow_q.modulus),
        .term  (mod_term)
    );

    bclk_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_bclk),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    // The final divide by 2 is the phase toggle.
    assign half_end   = run_q && mod_term;
    assign period_end = half_end && (phase_q == PH_HIGH);
    // Settings are taken while idle or at the end of a full period.
    assign load       = !run_q || period_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            run_q    <= 1'b0;
            err_q    <= 1'b0;
            phase_q  <= PH_LOW;
            rise_q   <= 1'b0;
            fall_q   <= 1'b0;
        end else begin
            rise_q <= half_end && (phase_q == PH_LOW);
            fall_q <= period_end;
            if (load) begin
                shadow_q <= live_set;
                run_q    <= cfg_drive_int && !set_forbidden(live_set);
                err_q    <= cfg_drive_int && set_forbidden(live_set);
                phase_q  <= PH_LOW;
            end else if (half_end) begin
                phase_q  <= PH_HIGH;
            end
        end
    end

    assign bclk_o    = cfg_drive_int && (phase_q == PH_HIGH);
    assign launch_en = cfg_drive_int ? (cfg_pol ? fall_q : rise_q)
                                     : (cfg_pol ? ext_fall : ext_rise);
    assign sample_en = cfg_drive_int ? (cfg_pol ? rise_q : fall_q)
                                     : (cfg_pol ? ext_rise : ext_fall);
    assign cfg_err   = err_q;
endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic bclk_o,
    input logic launch_en,
    input logic sample_en,
    input logic cfg_err,
    input logic cfg_pol,
    input logic cfg_drive_int
);
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(launch_en && sample_en));

    assert_single_launch_R4: assert property (@(posedge clk) disable iff (rst)
        launch_en |=> !launch_en);

    assert_single_sample_R4: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);

    assert_rise_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_drive_int) && cfg_drive_int && $rose(bclk_o))
        |-> (cfg_pol ? sample_en : launch_en));

    assert_fall_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_drive_int) && cfg_drive_int && $fell(bclk_o))
        |-> (cfg_pol ? launch_en : sample_en));

    assert_idle_on_error_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err) && cfg_drive_int)
        |-> (!bclk_o && !launch_en && !sample_en));

    assert_no_err_external_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_drive_int && $past(!cfg_drive_int)) |-> !cfg_err);
endmodule

bind bclk_gen bclk_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bclk_o        (bclk_o),
    .launch_en     (launch_en),
    .sample_en     (sample_en),
    .cfg_err       (cfg_err),
    .cfg_pol       (cfg_pol),
    .cfg_drive_int (cfg_drive_int)
);

// File: tb/sim_bclk_gen.sv
module sim_bclk_gen;
    import bclk_pkg::*;

    localparam int CLK_PERIOD      = 10;
    localparam int WAIT_LIMIT      = 20000;
    localparam int WATCHDOG_CYCLES = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fast = 1'b0;
    logic [MOD_W-1:0] modv = '0;
    logic             pol = 1'b0;
    logic             drive = 1'b1;
    logic             ext = 1'b0;
    logic             bclk_o, launch_en, sample_en, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bclk_gen u0 (
        .clk            (clk),
        .rst            (rst),
        .cfg_fast_range (fast),
        .cfg_modulus    (modv),
        .cfg_pol        (pol),
        .cfg_drive_int  (drive),
        .ext_bclk       (ext),
        .bclk_o         (bclk_o),
        .launch_en      (launch_en),
        .sample_en      (sample_en),
        .cfg_err        (cfg_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_len(input bit f, input int m);
        return (f ? 1 : 8) * (m + 1);
    endfunction

    task automatic wait_launch(input string req, output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!launch_en && waited < WAIT_LIMIT);
        if (!launch_en) check(1'b0, req, waited, WAIT_LIMIT);
    endtask

    // R1 R2 R3 R4: one full period measured after the new setting is in force
    task automatic measure(input bit f, input int m, input bit p);
        int h, w, cyc, high, samp, samp_at;
        h = half_len(f, m);
        @(negedge clk);
        fast = f; modv = m[MOD_W-1:0]; pol = p; drive = 1'b1;
        wait_launch("R1 launch timeout", w);
        wait_launch("R1 launch timeout", w);
        check(bclk_o == !p, "R3 bclk level at launch", longint'(bclk_o), longint'(!p));
        cyc = 0; high = 0; samp = 0; samp_at = -1;
        do begin
            if (bclk_o) high++;
            @(negedge clk);
            cyc++;
            if (sample_en) begin
                samp++;
                if (samp_at < 0) samp_at = cyc;
            end
        end while (!launch_en && cyc < WAIT_LIMIT);
        check(cyc == 2*h, "R1 period", cyc, 2*h);
        check(high == h, "R2 high time", high, h);
        check(samp == 1, "R4 sample strobes per period", samp, 1);
        check(samp_at == h, "R3 sample offset from launch", samp_at, h);
    endtask

    initial begin
        int w, hi, lo, bad;
        repeat (4) @(negedge clk);
        check({bclk_o, launch_en, sample_en, cfg_err} == 4'b0, "R8 reset outputs",
              {bclk_o, launch_en, sample_en, cfg_err}, 0);
        rst = 1'b0;
        wait_launch("R8 launch timeout", w);
        check(w == 9, "R8 first rising edge after reset", w, 9);

        // R1 R2 sweep over range and modulus
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 16; m++) begin
                if (!(r == 1 && m == 0)) measure(r[0], m, 1'b0);
            end
        end
        measure(1'b0, 255, 1'b0);
        measure(1'b1, 255, 1'b0);
        // R3 polarity 1
        measure(1'b0, 3, 1'b1);
        measure(1'b1, 6, 1'b1);
        measure(1'b1, 1, 1'b1);
        measure(1'b0, 0, 1'b1);

        // R6 change in mid high phase
        @(negedge clk);
        fast = 1'b1; modv = 8'd5; pol = 1'b0;
        wait_launch("R6 launch timeout", w);
        wait_launch("R6 launch timeout", w);
        hi = 1;
        repeat (2) begin
            @(negedge clk);
            if (bclk_o) hi++;
        end
        modv = 8'd2;
        do begin
            @(negedge clk);
            if (bclk_o) hi++;
        end while (bclk_o && hi < 100);
        check(hi == 6, "R6 high phase keeps old length", hi, 6);
        lo = 1;
        do begin
            @(negedge clk);
            if (!bclk_o) lo++;
        end while (!bclk_o && lo < 100);
        check(lo == 3, "R6 new length after period end", lo, 3);

        // R5 prohibited setting
        @(negedge clk);
        fast = 1'b1; modv = 8'd0;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!cfg_err && w < WAIT_LIMIT);
        check(cfg_err == 1'b1, "R5 error flag raised", cfg_err, 1);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (bclk_o || launch_en || sample_en) bad++;
            if (!cfg_err) bad++;
        end
        check(bad == 0, "R5 outputs idle while prohibited", bad, 0);
        modv = 8'd3;
        @(negedge clk);
        check(cfg_err == 1'b0, "R5 flag clears after legal setting", cfg_err, 0);
        wait_launch("R5 launch timeout", w);
        check(w == 4, "R5 restart timing", w, 4);

        // R7 external clock
        @(negedge clk);
        drive = 1'b0; pol = 1'b0; ext = 1'b0; fast = 1'b1; modv = 8'd0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (bclk_o || cfg_err || launch_en || sample_en) bad++;
        end
        check(bad == 0, "R7 pin low and no error in external mode", bad, 0);
        for (int i = 0; i < 4; i++) begin
            ext = 1'b1;
            @(negedge clk);
            check(!launch_en, "R7 no strobe before sync delay", launch_en, 0);
            @(negedge clk);
            check(launch_en && !sample_en, "R7 launch after two-stage sync", launch_en, 1);
            @(negedge clk);
            check(!launch_en, "R4 external launch one cycle", launch_en, 0);
            repeat (3 + i) @(negedge clk);
            ext = 1'b0;
            @(negedge clk);
            check(!sample_en, "R7 no early sample", sample_en, 0);
            @(negedge clk);
            check(sample_en && !launch_en, "R7 sample on external fall", sample_en, 1);
            @(negedge clk);
            check(!sample_en, "R4 external sample one cycle", sample_en, 0);
            repeat (2 + i) @(negedge clk);
        end
        pol = 1'b1;
        ext = 1'b1;
        repeat (2) @(negedge clk);
        check(sample_en && !launch_en, "R3 external rise samples with pol 1", sample_en, 1);
        repeat (4) @(negedge clk);
        ext = 1'b0;
        repeat (2) @(negedge clk);
        check(launch_en && !sample_en, "R3 external fall launches with pol 1", launch_en, 1);
        check(bclk_o == 1'b0, "R7 pin held low", bclk_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule